// File: doc/BRIEF.md
# Indexed Address Modifier with Counter Loop

This block turns the address part of an instruction into an effective address. A two-bit selector chooses one of three modifier words held in low store, or none at all. When a modifier is chosen, its address field is added to the instruction's immediate field. The sum wraps at 15 bits in normal mode and at 22 bits in extended mode. Data instructions supply a 12-bit immediate and jump instructions a 15-bit one.

The same block also executes the counter/modifier loop jump. In one accepted operation it reads the selected modifier word, adds one to its address field, subtracts one from its counter field, and writes the new word back. It reports the branch as taken when the new counter is zero. In normal mode the counter is the upper 9 bits and the address field is the lower 15 bits. In extended mode the counter is the upper 2 bits and the address field is the lower 22 bits. Both fields wrap within their own width.

Instructions enter on a valid/ready stream and results leave on a second one. An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new input is accepted. The modifier store is outside the block. It is read combinationally through `mod_rd_sel`/`mod_rd_data` and written on the accepting edge through the `mod_wr_*` pins.

Top module: `idxmod_unit`

## Requirements
- R1: When `in_m` = 0 and the operation is not a loop, the result address equals the immediate, with no modifier added.
- R2: For a data operation (`in_kind` = 0), only bits 11:0 of `in_n` are used, so the largest unmodified data address is 4095.
- R3: For a jump operation (`in_kind` = 1 or 3), all 15 bits of `in_n` are used, so the largest unmodified jump target is 32767.
- R4: In normal mode (`in_ext` = 0), with `in_m` from 1 to 3, the address is (modifier word bits 14:0 + immediate) mod 2^15. Counter bits 23:15 have no effect on the address.
- R5: In extended mode (`in_ext` = 1), with `in_m` from 1 to 3, the address is (modifier word bits 21:0 + immediate) mod 2^22.
- R6: A loop operation (`in_kind` = 2) in normal mode with `in_m` ≠ 0 writes word `in_m` on its accepting edge. Bits 14:0 become the old value + 1 mod 2^15, and bits 23:15 become the old value − 1 mod 2^9.
- R7: A loop operation in extended mode with `in_m` ≠ 0 writes back bits 21:0 as the old value + 1 mod 2^22, and bits 23:22 as the old value − 1 mod 4.
- R8: A loop operation reports `out_taken` = 1 exactly when the written-back counter is zero. Its `out_addr` is the 15-bit immediate, with no modifier added. All other operations report `out_taken` = 0.
- R9: A loop operation with `in_m` = 0 writes nothing, reports not taken, and returns the immediate as the address.
- R10: `in_ready` = !`out_valid` || `out_ready`. While stalled, `out_addr` and `out_taken` stay stable. A held input, including a loop, has no effect until it is accepted.
- R11: During and immediately after reset, `out_valid` = 0, `mod_wr_en` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Instruction valid |
| in_ready | output | 1 | Instruction can be accepted |
| in_m | input | 2 | Modifier selector, 0 = none |
| in_n | input | 15 | Immediate field |
| in_kind | input | 2 | 0 data, 1 jump, 2 loop, 3 jump |
| in_ext | input | 1 | Extended addressing mode |
| mod_rd_sel | output | 2 | Modifier word being read |
| mod_rd_data | input | 24 | Contents of the selected modifier word |
| mod_wr_en | output | 1 | Write-back strobe |
| mod_wr_sel | output | 2 | Modifier word to write |
| mod_wr_data | output | 24 | Updated modifier word |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_addr | output | 22 | Effective address or jump target |
| out_taken | output | 1 | Loop branch taken |

## Verification
A wrong field split or a wrong carry width shows up one cycle after acceptance as a wrong `out_addr`. It is most visible at the wrap points: modifier 0x7FFF plus a large immediate, and modifier 0x3FFFFF in extended mode. A wrong counter update shows up in two ways. The written word is visible on the accepting edge. The effect on `out_taken` can be delayed by several loop iterations, because the counter may only reach zero, or wrap past it, on a later pass. A broken stall path shows up as an output that changes while `out_ready` is low, or as a modifier word that changes before its loop is accepted.

// File: rtl/idxmod_pkg.sv
package idxmod_pkg;
  localparam int WORD_W  = 24;
  localparam int NRM_AW  = 15;
  localparam int EXT_AW  = 22;
  localparam int DATA_NW = 12;
  localparam int JMP_NW  = 15;
  localparam int SEL_W   = 2;

  typedef enum logic [1:0] {
    OP_DATA = 2'd0,
    OP_JUMP = 2'd1,
    OP_LOOP = 2'd2,
    OP_JALT = 2'd3
  } op_kind_t;
endpackage

// File: rtl/idxmod_split.sv
module idxmod_split #(
  parameter int WORD_W = 24,
  parameter int AW     = 15
) (
  input  logic [WORD_W-1:0]    word_i,
  output logic [AW-1:0]        mod_o,
  output logic [WORD_W-AW-1:0] cnt_o
);
  // Counter occupies the bits above the modifier field.
  assign mod_o = word_i[AW-1:0];
  assign cnt_o = word_i[WORD_W-1:AW];
endmodule

// File: rtl/idxmod_lane.sv
module idxmod_lane #(
  parameter int WORD_W = 24,
  parameter int AW     = 15,
  parameter int NW     = 15
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [NW-1:0]     n_i,
  input  logic              use_mod_i,
  output logic [AW-1:0]     ea_o,
  output logic [WORD_W-1:0] next_word_o,
  output logic              cnt_zero_o
);
  localparam int CW = WORD_W - AW;

  logic [AW-1:0] mod_f;
  logic [CW-1:0] cnt_f;
  logic [AW-1:0] mod_eff;
  logic [AW-1:0] mod_nx;
  logic [CW-1:0] cnt_nx;

  idxmod_split #(.WORD_W(WORD_W), .AW(AW)) u_split (
    .word_i (word_i),
    .mod_o  (mod_f),
    .cnt_o  (cnt_f)
  );

  always_comb begin
    mod_eff     = use_mod_i ? mod_f : '0;
    ea_o        = mod_eff + AW'(n_i);
    mod_nx      = mod_f + AW'(1);
    cnt_nx      = cnt_f - CW'(1);
    next_word_o = {cnt_nx, mod_nx};
    cnt_zero_o  = (cnt_nx == '0);
  end
endmodule

// File: rtl/idxmod_unit.sv
module idxmod_unit
  import idxmod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SEL_W-1:0]  in_m,
  input  logic [JMP_NW-1:0] in_n,
  input  logic [1:0]        in_kind,
  input  logic              in_ext,
  output logic [SEL_W-1:0]  mod_rd_sel,
  input  logic [WORD_W-1:0] mod_rd_data,
  output logic              mod_wr_en,
  output logic [SEL_W-1:0]  mod_wr_sel,
  output logic [WORD_W-1:0] mod_wr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [EXT_AW-1:0] out_addr,
  output logic              out_taken
);
  localparam int NLANE = 2;

  op_kind_t          kind;
  logic              accept;
  logic              is_loop;
  logic              is_data;
  logic              m_live;
  logic              use_mod;
  logic [JMP_NW-1:0] n_eff;
  logic [EXT_AW-1:0] lane_ea    [NLANE];
  logic [WORD_W-1:0] lane_word  [NLANE];
  logic              lane_zero  [NLANE];
  logic [EXT_AW-1:0] ea_sel;
  logic [WORD_W-1:0] word_sel;
  logic              zero_sel;
  logic [EXT_AW-1:0] res_addr;
  logic              res_taken;

  assign kind     = op_kind_t'(in_kind);
  assign is_loop  = (kind == OP_LOOP);
  assign is_data  = (kind == OP_DATA);
  assign m_live   = (in_m != '0);
  assign use_mod  = m_live && !is_loop;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign n_eff    = is_data ? JMP_NW'(in_n[DATA_NW-1:0]) : in_n;

  // Lane 0 handles normal mode, lane 1 extended mode.
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LAW = (g == 0) ? NRM_AW : EXT_AW;
    logic [LAW-1:0] ea_w;
    idxmod_lane #(.WORD_W(WORD_W), .AW(LAW), .NW(JMP_NW)) u_lane (
      .word_i      (mod_rd_data),
      .n_i         (n_eff),
      .use_mod_i   (use_mod),
      .ea_o        (ea_w),
      .next_word_o (lane_word[g]),
      .cnt_zero_o  (lane_zero[g])
    );
    assign lane_ea[g] = EXT_AW'(ea_w);
  end

  always_comb begin
    ea_sel   = in_ext ? lane_ea[1]   : lane_ea[0];
    word_sel = in_ext ? lane_word[1] : lane_word[0];
    zero_sel = in_ext ? lane_zero[1] : lane_zero[0];
    if (is_loop) begin
      res_addr  = EXT_AW'(in_n);
      res_taken = m_live && zero_sel;
    end else begin
      res_addr  = ea_sel;
      res_taken = 1'b0;
    end
  end

  assign mod_rd_sel  = in_m;
  assign mod_wr_en   = accept && is_loop && m_live;
  assign mod_wr_sel  = in_m;
  assign mod_wr_data = word_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_taken <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_addr  <= res_addr;
      out_taken <= res_taken;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/idxmod_chk.sv
module idxmod_chk
  import idxmod_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [SEL_W-1:0]  in_m,
  input logic [JMP_NW-1:0] in_n,
  input logic [1:0]        in_kind,
  input logic              in_ext,
  input logic [SEL_W-1:0]  mod_rd_sel,
  input logic              mod_wr_en,
  input logic [SEL_W-1:0]  mod_wr_sel,
  input logic [WORD_W-1:0] mod_wr_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [EXT_AW-1:0] out_addr,
  input logic              out_taken
);
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_taken));

  assert_stall_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_wr_loop_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mod_wr_en |-> in_valid && in_ready && in_kind == 2'd2 && in_m != '0);

  assert_wr_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mod_wr_en |-> mod_wr_sel == in_m && mod_rd_sel == in_m);

  assert_no_wr_m0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_m == '0 |-> !mod_wr_en);

  assert_taken_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mod_wr_en && !in_ext |=> out_valid &&
      (out_taken == ($past(mod_wr_data[WORD_W-1:NRM_AW]) == '0)));

  assert_taken_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_taken |-> out_addr[EXT_AW-1:JMP_NW] == '0);

  assert_m0_jump_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_m == '0 && in_kind == 2'd1 |=>
      out_addr == EXT_AW'($past(in_n)));
endmodule

bind idxmod_unit idxmod_chk u_chk (.*);

// File: tb/sim_idxmod_unit.sv
module sim_idxmod_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_m = '0;
  logic [14:0] in_n = '0;
  logic [1:0]  in_kind = '0;
  logic        in_ext = 1'b0;
  logic [1:0]  mod_rd_sel;
  logic [23:0] mod_rd_data;
  logic        mod_wr_en;
  logic [1:0]  mod_wr_sel;
  logic [23:0] mod_wr_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [21:0] out_addr;
  logic        out_taken;

  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = '0;
  logic [23:0] ld_data = '0;
  logic [23:0] store [4];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (mod_wr_en) store[mod_wr_sel] <= mod_wr_data;
    else if (ld_en) store[ld_sel] <= ld_data;
  end
  assign mod_rd_data = store[mod_rd_sel];

  idxmod_unit u0 (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(logic [1:0] sel, logic [23:0] data);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_data = data;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // Issue one operation with the output drained, check result a cycle later.
  task automatic op(string tag, logic [1:0] m, logic [14:0] n, logic [1:0] k,
                    logic x, logic [21:0] exp_a, logic exp_t);
    @(negedge clk);
    in_valid = 1'b1; in_m = m; in_n = n; in_kind = k; in_ext = x;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, 32'(out_valid), 32'd1);
    check({tag, " addr"}, 32'(out_addr), 32'(exp_a));
    check({tag, " taken"}, 32'(out_taken), 32'(exp_t));
  endtask

  task automatic t_reset;
    check("R11 out_valid", 32'(out_valid), 32'd0);
    check("R11 wr_en", 32'(mod_wr_en), 32'd0);
    check("R11 in_ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_unmodified;
    op("R1 R2 data 4095", 2'd0, 15'd4095, 2'd0, 1'b0, 22'd4095, 1'b0);
    op("R2 data high bits dropped", 2'd0, 15'h7FFF, 2'd0, 1'b0, 22'hFFF, 1'b0);
    op("R1 R3 jump 32767", 2'd0, 15'h7FFF, 2'd1, 1'b0, 22'h7FFF, 1'b0);
    op("R3 kind3 jump", 2'd0, 15'h4001, 2'd3, 1'b0, 22'h4001, 1'b0);
    op("R1 data 0", 2'd0, 15'd0, 2'd0, 1'b0, 22'd0, 1'b0);
  endtask

  task automatic t_normal;
    poke(2'd1, {9'h1AB, 15'd100});
    poke(2'd2, {9'd0, 15'h7FFF});
    poke(2'd3, {9'h1FF, 15'h7000});
    op("R4 m1 counter ignored", 2'd1, 15'd5, 2'd0, 1'b0, 22'd105, 1'b0);
    op("R4 R2 m2 wrap", 2'd2, 15'hFFFF >> 1, 2'd0, 1'b0, 22'hFFE, 1'b0);
    op("R4 R3 m3 jump wrap", 2'd3, 15'h7FFF, 2'd1, 1'b0, 22'h6FFF, 1'b0);
    op("R4 m2 n0", 2'd2, 15'd0, 2'd0, 1'b0, 22'h7FFF, 1'b0);
  endtask

  task automatic t_extended;
    poke(2'd1, 24'hC0_0010);
    poke(2'd2, 24'h3F_FFFF);
    poke(2'd3, 24'h00_7FFF);
    op("R5 m1 data", 2'd1, 15'd4095, 2'd0, 1'b1, 22'h100F, 1'b0);
    op("R5 m2 22-bit wrap", 2'd2, 15'd2, 2'd1, 1'b1, 22'd1, 1'b0);
    op("R5 m3 past 15 bits", 2'd3, 15'd1, 2'd1, 1'b1, 22'h8000, 1'b0);
  endtask

  task automatic t_loop_normal;
    poke(2'd1, {9'd2, 15'd10});
    op("R8 loop cnt 2->1", 2'd1, 15'd300, 2'd2, 1'b0, 22'd300, 1'b0);
    check("R6 word after pass 1", 32'(store[1]), 32'({9'd1, 15'd11}));
    op("R8 loop cnt 1->0", 2'd1, 15'd300, 2'd2, 1'b0, 22'd300, 1'b1);
    check("R6 word after pass 2", 32'(store[1]), 32'({9'd0, 15'd12}));
    op("R8 loop cnt 0->511", 2'd1, 15'd300, 2'd2, 1'b0, 22'd300, 1'b0);
    check("R6 counter wrap", 32'(store[1]), 32'({9'h1FF, 15'd13}));
    poke(2'd2, {9'd1, 15'h7FFF});
    op("R8 loop m2 taken", 2'd2, 15'h7FFF, 2'd2, 1'b0, 22'h7FFF, 1'b1);
    check("R6 modifier wrap", 32'(store[2]), 32'd0);
  endtask

  task automatic t_loop_ext;
    poke(2'd3, {2'd1, 22'h3FFFFF});
    op("R7 R8 ext loop taken", 2'd3, 15'd77, 2'd2, 1'b1, 22'd77, 1'b1);
    check("R7 ext word wrap", 32'(store[3]), 32'd0);
    op("R7 ext loop cnt wrap", 2'd3, 15'd77, 2'd2, 1'b1, 22'd77, 1'b0);
    check("R7 ext word 2", 32'(store[3]), 32'({2'd3, 22'd1}));
  endtask

  task automatic t_loop_m0;
    poke(2'd1, 24'h000001);
    poke(2'd2, 24'h000002);
    poke(2'd3, 24'h000003);
    op("R9 loop m0", 2'd0, 15'd1234, 2'd2, 1'b0, 22'd1234, 1'b0);
    check("R9 word1 untouched", 32'(store[1]), 32'h1);
    check("R9 word2 untouched", 32'(store[2]), 32'h2);
    check("R9 word3 untouched", 32'(store[3]), 32'h3);
  endtask

  task automatic t_backpressure;
    poke(2'd1, {9'd5, 15'd40});
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_m = 2'd0; in_n = 15'd7; in_kind = 2'd0; in_ext = 1'b0;
    @(negedge clk);
    check("R10 first accepted", 32'(out_addr), 32'd7);
    in_m = 2'd1; in_n = 15'd900; in_kind = 2'd2;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 stalled ready", 32'(in_ready), 32'd0);
      check("R10 held addr", 32'(out_addr), 32'd7);
      check("R10 held loop no write", 32'(store[1]), 32'({9'd5, 15'd40}));
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 accepted after release", 32'(out_addr), 32'd900);
    check("R10 single write-back", 32'(store[1]), 32'({9'd4, 15'd41}));
    @(negedge clk);
    check("R10 drained", 32'(out_valid), 32'd0);
  endtask

  initial begin
    #1;
    check("R11 in reset", 32'(out_valid), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unmodified();
    t_normal();
    t_extended();
    t_loop_normal();
    t_loop_ext();
    t_loop_m0();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule